// File: doc/BRIEF.md
# Debug Trap Status Controller

This block merges every debug condition of an execution core into two exception requests and records what caused each one. Breakpoint slots report execute hits when an instruction is about to run and data hits when it completes. A trap-flag input enables single stepping. A branch-step mode bit narrows stepping to control transfers only. An access-protect enable makes any attempt to touch the debug registers raise an exception. Causes that must be seen before the instruction runs (execute hits, protected access) raise the fault request. Causes seen after completion (data hits, single step) raise the trap request.

A request stays up until the core acknowledges handler entry. At that acknowledge the cause bits of the exception being entered are ORed into a sticky status register, and one cycle later the block pulses a clear for the access-protect enable. When the entry is for a single step, it also pulses a clear for the trap flag. Software clears the status register by writing it. The core reports each repeated string iteration as a separate retire, so data hits can trap between iterations. Saving the machine state and dispatching the vector are left to the core.

Top module: `dbg_trap_ctrl`

## Requirements
- R1: Status layout: bit 14 is single step, bit 13 is protected debug-register access, and bits 3..0 are breakpoint slots 3..0. All other bits always read 0. Bits are sticky. Only a write (`sts_wr`) changes the register apart from entry, and a write loads `sts_wdata` masked to the implemented bits.
- R2: A cycle with `issue_vld` and either a nonzero `exec_hit` or (`dr_access` and `gd_en`) raises `fault_req` from the next cycle until it is taken. `exec_hit` and `dr_access` have no effect without `issue_vld`.
- R3: A cycle with `retire_vld` and a nonzero `data_hit` raises `trap_req` from the next cycle until it is taken. `data_hit` has no effect without `retire_vld`.
- R4: While a trap is pending, `fault_req` is held low, so the after-completion cause of an earlier instruction is entered before a before-execution cause. The two requests are never high together.
- R5: An `ack` while a request is high enters the trap if one is pending, and the fault otherwise. It drops that request, ORs its cause bits into the status register, and pulses `gd_clr` for one cycle after the acknowledge. An `ack` with no request has no effect.
- R6: A retire produces a step cause (status bit 14) only if the trap flag was 1 at the previous retire. So the instruction that sets the flag is not stepped, and the instruction that clears it still is. Entering a step trap pulses `tf_clr` one cycle after the acknowledge and disarms stepping until the next retire.
- R7: With `br_mode` at 1, a step cause arises only on a retire that has `xfer` set.
- R8: Causes from several retires (or issues) before entry accumulate, and entry records all of them.
- R9: After reset both requests, both clear pulses and the whole status register are 0, and stepping is disarmed.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| issue_vld | input | 1 | An instruction is about to execute |
| exec_hit | input | NSLOT | Execute-breakpoint hits for the issuing instruction |
| dr_access | input | 1 | Issuing instruction accesses a debug register |
| gd_en | input | 1 | Access-protect enable |
| retire_vld | input | 1 | An instruction (or string iteration) completed |
| data_hit | input | NSLOT | Data/I/O breakpoint hits for the retiring instruction |
| xfer | input | 1 | Retiring instruction was a control transfer |
| tf | input | 1 | Trap flag value after the retiring instruction |
| br_mode | input | 1 | Step on control transfers only |
| ack | input | 1 | Handler entry acknowledge |
| sts_wr | input | 1 | Software write of the status register |
| sts_wdata | input | STW | Status write data |
| fault_req | output | 1 | Exception request before execution |
| trap_req | output | 1 | Exception request after completion |
| status | output | STW | Status register |
| tf_clr | output | 1 | Pulse: clear the trap flag |
| gd_clr | output | 1 | Pulse: clear the access-protect enable |

## Verification
The bench drives an execute hit and a data hit in the same cycle and checks that the trap is entered first. A design that ordered them the other way would show both requests high, or would record the slot-3 bit before the slot-0 bit. It sets the trap flag on one retire and checks that no step comes from that retire but one does from the next. An off-by-one arm would step the instruction that sets the flag. It checks that branch-step mode suppresses steps on plain retires, that hits without their strobe are ignored, and that cause bits survive everything except a software write. A random phase then compares all outputs every cycle against a behavioural model.

// File: rtl/dbg_trap_ctrl.sv
module dbg_trap_ctrl #(
  parameter int NSLOT  = 4,
  parameter int STW    = 16,
  parameter int BS_POS = 14,
  parameter int BD_POS = 13
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             issue_vld,
  input  logic [NSLOT-1:0] exec_hit,
  input  logic             dr_access,
  input  logic             gd_en,
  input  logic             retire_vld,
  input  logic [NSLOT-1:0] data_hit,
  input  logic             xfer,
  input  logic             tf,
  input  logic             br_mode,
  input  logic             ack,
  input  logic             sts_wr,
  input  logic [STW-1:0]   sts_wdata,
  output logic             fault_req,
  output logic             trap_req,
  output logic [STW-1:0]   status,
  output logic             tf_clr,
  output logic             gd_clr
);

  localparam logic [STW-1:0] BS_M   = STW'(1) << BS_POS;
  localparam logic [STW-1:0] BD_M   = STW'(1) << BD_POS;
  localparam logic [STW-1:0] SLOT_M = STW'((1 << NSLOT) - 1);
  localparam logic [STW-1:0] ST_M   = BS_M | BD_M | SLOT_M;

  logic [STW-1:0] t_cause, f_cause, st_q;
  logic           t_pend, f_pend, tf_armed, tf_clr_q, gd_clr_q;

  logic           take_t, take_f, step_hit;
  logic [STW-1:0] t_new, f_new, entry_set;

  assign take_t    = ack & t_pend;
  assign take_f    = ack & ~t_pend & f_pend;
  assign step_hit  = retire_vld & tf_armed & (~br_mode | xfer);
  assign t_new     = retire_vld ? (STW'(data_hit) | (step_hit ? BS_M : '0)) : '0;
  assign f_new     = issue_vld ? (STW'(exec_hit) | ((dr_access & gd_en) ? BD_M : '0)) : '0;
  assign entry_set = take_t ? t_cause : (take_f ? f_cause : '0);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      t_cause  <= '0;
      f_cause  <= '0;
      t_pend   <= 1'b0;
      f_pend   <= 1'b0;
      st_q     <= '0;
      tf_armed <= 1'b0;
      tf_clr_q <= 1'b0;
      gd_clr_q <= 1'b0;
    end else begin
      t_cause  <= (take_t ? '0 : t_cause) | t_new;
      f_cause  <= (take_f ? '0 : f_cause) | f_new;
      t_pend   <= (t_pend & ~take_t) | (|t_new);
      f_pend   <= (f_pend & ~take_f) | (|f_new);
      st_q     <= ((sts_wr ? sts_wdata : st_q) & ST_M) | entry_set;
      if (retire_vld)
        tf_armed <= tf;
      else if (take_t & t_cause[BS_POS])
        tf_armed <= 1'b0;
      tf_clr_q <= take_t & t_cause[BS_POS];
      gd_clr_q <= take_t | take_f;
    end
  end

  assign trap_req  = t_pend;
  assign fault_req = f_pend & ~t_pend;
  assign status    = st_q;
  assign tf_clr    = tf_clr_q;
  assign gd_clr    = gd_clr_q;

endmodule

// File: rtl/dbg_trap_chk.sv
module dbg_trap_chk #(
  parameter int NSLOT = 4,
  parameter int STW   = 16
) (
  input logic           clk,
  input logic           rst_n,
  input logic           issue_vld,
  input logic           retire_vld,
  input logic           ack,
  input logic           sts_wr,
  input logic           fault_req,
  input logic           trap_req,
  input logic [STW-1:0] status,
  input logic           tf_clr,
  input logic           gd_clr
);

  p_excl_r4: assert property (@(posedge clk) disable iff (!rst_n)
    !(trap_req && fault_req));

  p_sticky_r1: assert property (@(posedge clk) disable iff (!rst_n)
    !sts_wr |=> ((status & $past(status)) == $past(status)));

  p_trap_hold_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (trap_req && !ack) |=> trap_req);

  p_trap_src_r3: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(trap_req) |-> $past(retire_vld));

  p_fault_hold_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (fault_req && !ack) |=> (fault_req || trap_req));

  p_fault_src_r2: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(fault_req) |-> ($past(issue_vld) || $past(trap_req)));

  p_gd_clr_r5: assert property (@(posedge clk) disable iff (!rst_n)
    gd_clr |-> $past(ack && (trap_req || fault_req)));

  p_tf_clr_r6: assert property (@(posedge clk) disable iff (!rst_n)
    tf_clr |-> (status[14] && gd_clr));

endmodule

bind dbg_trap_ctrl dbg_trap_chk #(.NSLOT(NSLOT), .STW(STW)) u_chk (
  .clk(clk), .rst_n(rst_n), .issue_vld(issue_vld), .retire_vld(retire_vld),
  .ack(ack), .sts_wr(sts_wr), .fault_req(fault_req), .trap_req(trap_req),
  .status(status), .tf_clr(tf_clr), .gd_clr(gd_clr)
);

// File: tb/test_dbg_trap_ctrl.sv
module test_dbg_trap_ctrl;
  localparam int CLK_PERIOD = 10;
  localparam int NS = 4;
  localparam int SW = 16;
  localparam int IMPL = 32'h600F;

  logic clk = 1'b0, rst_n = 1'b0;
  logic issue_vld = 0, dr_access = 0, gd_en = 0, retire_vld = 0, xfer = 0, tf = 0;
  logic br_mode = 0, ack = 0, sts_wr = 0;
  logic [NS-1:0] exec_hit = '0, data_hit = '0;
  logic [SW-1:0] sts_wdata = '0;
  logic fault_req, trap_req, tf_clr, gd_clr;
  logic [SW-1:0] status;

  int total = 0, bad = 0, cycles = 0;
  bit done = 0;

  int m_tc, m_fc, m_st;
  bit m_tp, m_fp, m_arm, m_tfclr, m_gdclr;

  dbg_trap_ctrl #(.NSLOT(NS), .STW(SW)) i_dbg_trap_ctrl (
    .clk(clk), .rst_n(rst_n), .issue_vld(issue_vld), .exec_hit(exec_hit),
    .dr_access(dr_access), .gd_en(gd_en), .retire_vld(retire_vld),
    .data_hit(data_hit), .xfer(xfer), .tf(tf), .br_mode(br_mode), .ack(ack),
    .sts_wr(sts_wr), .sts_wdata(sts_wdata), .fault_req(fault_req),
    .trap_req(trap_req), .status(status), .tf_clr(tf_clr), .gd_clr(gd_clr));

  always #(CLK_PERIOD/2) clk = ~clk;

  task automatic chk(input string req, input int act, input int exp);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s act=%0h exp=%0h t=%0t", req, act, exp, $time);
    end
  endtask

  // behavioural reference, updated on each rising edge
  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_tc = 0; m_fc = 0; m_st = 0; m_tp = 0; m_fp = 0;
      m_arm = 0; m_tfclr = 0; m_gdclr = 0;
    end else begin
      bit tk_t, tk_f, stp;
      int nt, nf, ent;
      tk_t = ack && m_tp;
      tk_f = ack && !m_tp && m_fp;
      ent = tk_t ? m_tc : (tk_f ? m_fc : 0);
      m_st = ((sts_wr ? int'(sts_wdata) : m_st) & IMPL) | ent;
      m_tfclr = tk_t && m_tc[14];
      m_gdclr = tk_t || tk_f;
      stp = retire_vld && m_arm && (!br_mode || xfer);
      nt = 0; nf = 0;
      if (retire_vld) nt = int'(data_hit) | (stp ? 32'h4000 : 0);
      if (issue_vld) nf = int'(exec_hit) | ((dr_access && gd_en) ? 32'h2000 : 0);
      if (retire_vld) m_arm = tf;
      else if (tk_t && m_tc[14]) m_arm = 0;
      if (tk_t) m_tc = 0;
      if (tk_f) m_fc = 0;
      m_tc |= nt; m_fc |= nf;
      m_tp = (m_tp && !tk_t) || (nt != 0);
      m_fp = (m_fp && !tk_f) || (nf != 0);
    end
  end

  always @(negedge clk) if (rst_n && !done) begin
    chk("R3 model trap_req", int'(trap_req), int'(m_tp));
    chk("R4 model fault_req", int'(fault_req), int'(m_fp && !m_tp));
    chk("R1 model status", int'(status), m_st);
    chk("R6 model tf_clr", int'(tf_clr), int'(m_tfclr));
    chk("R5 model gd_clr", int'(gd_clr), int'(m_gdclr));
  end

  always @(posedge clk) begin
    cycles++;
    if (cycles > 200000 && !done) begin
      done = 1;
      bad++; total++;
      $display("FAIL watchdog act=%0d exp=<200000", cycles);
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  task automatic idle();
    issue_vld = 0; exec_hit = '0; dr_access = 0; retire_vld = 0; data_hit = '0;
    xfer = 0; ack = 0; sts_wr = 0; sts_wdata = '0;
  endtask

  task automatic step();
    @(posedge clk); @(negedge clk);
    idle();
  endtask

  initial begin
    idle();
    repeat (3) @(negedge clk);
    rst_n = 1;
    // R9 reset state
    chk("R9 status", int'(status), 0);
    chk("R9 reqs", int'({trap_req, fault_req, tf_clr, gd_clr}), 0);

    // R3 ignored without strobe
    data_hit = 4'h4; step();
    chk("R3 no retire", int'(trap_req), 0);
    retire_vld = 1; data_hit = 4'h4; step();
    chk("R3 trap raised", int'(trap_req), 1);
    step();
    chk("R3 trap held", int'(trap_req), 1);
    ack = 1; step();
    chk("R5 trap dropped", int'(trap_req), 0);
    chk("R5 status slot2", int'(status), 32'h0004);
    chk("R5 gd_clr pulse", int'(gd_clr), 1);
    step();
    chk("R5 gd_clr one cycle", int'(gd_clr), 0);
    ack = 1; step();
    chk("R5 ack w/o request", int'({gd_clr, status}), 32'h0004);

    // R2 fault path
    exec_hit = 4'h2; dr_access = 1; gd_en = 1; step();
    chk("R2 no issue", int'(fault_req), 0);
    issue_vld = 1; exec_hit = 4'h2; step();
    chk("R2 fault raised", int'(fault_req), 1);
    ack = 1; step();
    chk("R2 status slot1", int'(status), 32'h0006);

    // R1 software write
    sts_wr = 1; sts_wdata = 16'hFFFF; step();
    chk("R1 masked write", int'(status), 32'h600F);
    sts_wr = 1; sts_wdata = 16'h0000; step();
    chk("R1 clear by write", int'(status), 0);

    // R5 protected access
    issue_vld = 1; dr_access = 1; step();
    chk("R2 protect fault", int'(fault_req), 1);
    ack = 1; step();
    chk("R5 status BD", int'(status), 32'h2000);
    chk("R5 gd_clr on protect", int'(gd_clr), 1);
    gd_en = 0;
    sts_wr = 1; step();

    // R4 ordering
    retire_vld = 1; data_hit = 4'h1; issue_vld = 1; exec_hit = 4'h8; step();
    chk("R4 trap first", int'({trap_req, fault_req}), 2);
    ack = 1; step();
    chk("R4 fault after trap", int'({trap_req, fault_req}), 1);
    chk("R4 status after trap", int'(status), 32'h0001);
    ack = 1; step();
    chk("R4 status after fault", int'(status), 32'h0009);
    sts_wr = 1; step();

    // R6 single step
    retire_vld = 1; tf = 1; step();
    chk("R6 setter not stepped", int'(trap_req), 0);
    retire_vld = 1; tf = 0; step();
    chk("R6 next stepped", int'(trap_req), 1);
    ack = 1; step();
    chk("R6 tf_clr pulse", int'(tf_clr), 1);
    chk("R6 status BS", int'(status), 32'h4000);
    retire_vld = 1; step();
    chk("R6 disarmed", int'(trap_req), 0);
    sts_wr = 1; step();

    // R7 branch-step
    br_mode = 1; retire_vld = 1; tf = 1; step();
    retire_vld = 1; step();
    chk("R7 plain retire no step", int'(trap_req), 0);
    retire_vld = 1; xfer = 1; step();
    chk("R7 transfer stepped", int'(trap_req), 1);
    ack = 1; tf = 0; br_mode = 0; step();
    sts_wr = 1; step();

    // R8 accumulation
    retire_vld = 1; data_hit = 4'h1; step();
    retire_vld = 1; data_hit = 4'h2; step();
    ack = 1; step();
    chk("R8 accumulated", int'(status), 32'h0003);

    // random phase against the model
    for (int i = 0; i < 3000; i++) begin
      issue_vld  = ($urandom % 3) == 0;
      exec_hit   = (($urandom % 5) == 0) ? NS'($urandom) : '0;
      dr_access  = ($urandom % 6) == 0;
      gd_en      = ($urandom % 2) == 0;
      retire_vld = ($urandom % 2) == 0;
      data_hit   = (($urandom % 5) == 0) ? NS'($urandom) : '0;
      xfer       = ($urandom % 4) == 0;
      if (($urandom % 8) == 0) tf = ~tf;
      if (($urandom % 50) == 0) br_mode = ~br_mode;
      ack        = ($urandom % 3) == 0;
      sts_wr     = ($urandom % 20) == 0;
      sts_wdata  = SW'($urandom);
      step();
    end

    done = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule